// File: doc/BRIEF.md
# Byte-in, word-out multi-slot packet buffer

This block is the storage between a byte-wide network receive path and a 32-bit bus-transaction engine. The network side writes one byte per cycle of its own clock. The transaction side reads whole 32-bit words on a separate, slower clock. The two clocks have no fixed frequency or phase relationship. The storage is split into packet slots so that several packets can be held at once. A byte address is the slot index joined to a byte offset inside the slot. A word address is the slot index joined to a word index inside the slot.

The memory is written as behavioural code and built from four byte-lane banks. Every bank has a write port in the write clock domain and a registered read port in the read clock domain. A write is staged through one register before it reaches its bank. A read returns its word on the first read-clock edge after the address is presented.

The sender decides which slot to fill. Pacing traffic between the two sides and passing slot pointers across the clock boundary are left to logic around the block. `SLOT_BITS` (default 4, 16 slots) sets the number of slots. `OFS_BITS` sets the bytes per slot and may range from 2 to 13 (8 KB slots). Its default is 7, which keeps the default instance small. Total capacity is 2^(SLOT_BITS+OFS_BITS) bytes.

Top module: `pkt_xfer_ram`

## Requirements
- R1: A byte on `wr_byte` with `wr_en` high at a `wr_clk` rising edge is stored at byte address {`wr_slot`, `wr_ofs`}. The store is committed on the following `wr_clk` edge, and from then on a read of that location returns it.
- R2: Lane order inside a read word: the byte whose offset ends in binary 00 is in `rd_data[31:24]`, 01 is in `[23:16]`, 10 is in `[15:8]` and 11 is in `[7:0]`.
- R3: A read of {`rd_slot`, `rd_word`} returns the four bytes at offsets 4*`rd_word` to 4*`rd_word`+3 of slot `rd_slot`.
- R4: Read data is registered. `rd_data` changes only at a `rd_clk` rising edge. It shows the word addressed before that edge and keeps it until the next edge.
- R5: Writing a byte in one slot leaves the byte at the same offset in every other slot unchanged.
- R6: `rd_rst` is synchronous and active high. At each `rd_clk` edge where it is high, `rd_data` becomes 0, whatever the address.
- R7: `wr_rst` is synchronous and active high. A byte presented while it is high is discarded, and the memory keeps its old contents.
- R8: Writing a single byte changes only its own lane. The other three bytes of the same word keep their values.
- R9: All 2^(SLOT_BITS+OFS_BITS) byte locations are distinct. The first word of slot 0 and the last word of the highest slot hold independent data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock (network domain) |
| wr_rst | input | 1 | Synchronous active-high reset of the write stage |
| wr_en | input | 1 | Store `wr_byte` this cycle |
| wr_slot | input | SLOT_BITS | Packet slot to write |
| wr_ofs | input | OFS_BITS | Byte offset inside the slot |
| wr_byte | input | 8 | Byte to store |
| rd_clk | input | 1 | Read-side clock (transaction domain, slower) |
| rd_rst | input | 1 | Synchronous active-high clear of the read register |
| rd_slot | input | SLOT_BITS | Packet slot to read |
| rd_word | input | OFS_BITS-2 | Word index inside the slot |
| rd_data | output | 32 | Registered read word |

## Verification
The hardest case to reach from the ports is a read that overlaps a single-byte change, where only one lane of an otherwise filled word may differ. Reaching it needs the whole memory filled with an address-dependent pattern first, so that every lane holds a known value. The bench then rewrites isolated bytes in one slot, including one presented under write reset. It reads back the affected words and the same word index in neighbouring slots. These reads are issued on consecutive read cycles so that the hold-until-next-edge behaviour of the output register is checked in the same run.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);

    // Byte offset low bits -> lane write mask; offset 0 lands in the top lane.
    function automatic logic [LANES-1:0] lane_mask(input logic [LANE_W-1:0] lo);
        logic [LANES-1:0] m;
        m = '0;
        m[LANES-1-int'(lo)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pxr_wr_stage.sv
module pxr_wr_stage
    import pxr_pkg::*;
#(
    parameter int SLOT_BITS = 4,
    parameter int OFS_BITS  = 7,
    localparam int WORD_BITS = OFS_BITS - LANE_W,
    localparam int WADDR_W   = SLOT_BITS + WORD_BITS
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst,
    input  logic                 wr_en,
    input  logic [SLOT_BITS-1:0] wr_slot,
    input  logic [OFS_BITS-1:0]  wr_ofs,
    input  logic [BYTE_W-1:0]    wr_byte,
    output logic [LANES-1:0]     lane_we,
    output logic [WADDR_W-1:0]   lane_addr,
    output logic [BYTE_W-1:0]    lane_data
);

    typedef struct packed {
        logic [LANES-1:0]   we;
        logic [WADDR_W-1:0] addr;
        logic [BYTE_W-1:0]  data;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = '0;
        if (wr_en) begin
            st_d.we   = lane_mask(wr_ofs[LANE_W-1:0]);
            st_d.addr = {wr_slot, wr_ofs[OFS_BITS-1:LANE_W]};
            st_d.data = wr_byte;
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_we   = st_q.we;
    assign lane_addr = st_q.addr;
    assign lane_data = st_q.data;

endmodule

// File: rtl/pxr_lane_bank.sv
module pxr_lane_bank
    import pxr_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = mem[raddr];
        if (rd_rst) begin
            rdata_d = '0;
        end
    end

    always_ff @(posedge rd_clk) begin
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pkt_xfer_ram.sv
module pkt_xfer_ram
    import pxr_pkg::*;
#(
    parameter int SLOT_BITS = 4,
    parameter int OFS_BITS  = 7,
    localparam int WORD_BITS = OFS_BITS - LANE_W,
    localparam int WADDR_W   = SLOT_BITS + WORD_BITS
) (
    input  logic                  wr_clk,
    input  logic                  wr_rst,
    input  logic                  wr_en,
    input  logic [SLOT_BITS-1:0]  wr_slot,
    input  logic [OFS_BITS-1:0]   wr_ofs,
    input  logic [7:0]            wr_byte,
    input  logic                  rd_clk,
    input  logic                  rd_rst,
    input  logic [SLOT_BITS-1:0]  rd_slot,
    input  logic [WORD_BITS-1:0]  rd_word,
    output logic [31:0]           rd_data
);

    logic [LANES-1:0]   lane_we;
    logic [WADDR_W-1:0] lane_addr;
    logic [BYTE_W-1:0]  lane_data;
    logic [WADDR_W-1:0] rd_addr;

    assign rd_addr = {rd_slot, rd_word};

    pxr_wr_stage #(
        .SLOT_BITS (SLOT_BITS),
        .OFS_BITS  (OFS_BITS)
    ) u_wr (
        .wr_clk    (wr_clk),
        .wr_rst    (wr_rst),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_ofs    (wr_ofs),
        .wr_byte   (wr_byte),
        .lane_we   (lane_we),
        .lane_addr (lane_addr),
        .lane_data (lane_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pxr_lane_bank #(
            .ADDR_W (WADDR_W)
        ) u_bank (
            .wr_clk (wr_clk),
            .we     (lane_we[l]),
            .waddr  (lane_addr),
            .wdata  (lane_data),
            .rd_clk (rd_clk),
            .rd_rst (rd_rst),
            .raddr  (rd_addr),
            .rdata  (rd_data[BYTE_W*l +: BYTE_W])
        );
    end

endmodule

// File: rtl/pkt_xfer_ram_chk.sv
module pkt_xfer_ram_chk #(
    parameter int SLOT_BITS = 4,
    parameter int OFS_BITS  = 7,
    localparam int WADDR_W  = SLOT_BITS + OFS_BITS - 2
) (
    input logic                 wr_clk,
    input logic                 wr_rst,
    input logic                 wr_en,
    input logic [SLOT_BITS-1:0] wr_slot,
    input logic [OFS_BITS-1:0]  wr_ofs,
    input logic [3:0]           lane_we,
    input logic [WADDR_W-1:0]   lane_addr,
    input logic                 rd_clk,
    input logic                 rd_rst,
    input logic [31:0]          rd_data
);

    AST_LANE_ONEHOT: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $onehot0(lane_we)); // R2

    AST_LANE_TOP_FIRST: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_ofs[1:0] == 2'd0) |=> lane_we == 4'b1000); // R2

    AST_WORD_ADDR: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_en |=> lane_addr == $past({wr_slot, wr_ofs[OFS_BITS-1:2]})); // R1

    AST_WR_DROP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $fell(wr_rst) |-> lane_we == 4'b0000); // R7

    AST_RD_CLEAR: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_rst) |-> rd_data == 32'd0); // R6

endmodule

bind pkt_xfer_ram pkt_xfer_ram_chk #(
    .SLOT_BITS (SLOT_BITS),
    .OFS_BITS  (OFS_BITS)
) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst    (wr_rst),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .wr_ofs    (wr_ofs),
    .lane_we   (lane_we),
    .lane_addr (lane_addr),
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .rd_data   (rd_data)
);

// File: tb/pkt_xfer_ram_tb.sv
module pkt_xfer_ram_tb;

    localparam int  SLOT_BITS = 4;
    localparam int  OFS_BITS  = 7;
    localparam int  WORD_BITS = OFS_BITS - 2;
    localparam int  BYTES     = 1 << (SLOT_BITS + OFS_BITS);
    localparam int  NSLOT     = 1 << SLOT_BITS;
    localparam int  NWORD     = 1 << WORD_BITS;
    localparam time WR_PERIOD = 8;
    localparam time RD_PERIOD = 30;

    logic                 wr_clk = 1'b0, rd_clk = 1'b0;
    logic                 wr_rst = 1'b1, rd_rst = 1'b1;
    logic                 wr_en = 1'b0;
    logic [SLOT_BITS-1:0] wr_slot = '0, rd_slot = '0;
    logic [OFS_BITS-1:0]  wr_ofs = '0;
    logic [7:0]           wr_byte = '0;
    logic [WORD_BITS-1:0] rd_word = '0;
    logic [31:0]          rd_data;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    pkt_xfer_ram #(.SLOT_BITS(SLOT_BITS), .OFS_BITS(OFS_BITS)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_ofs(wr_ofs), .wr_byte(wr_byte), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data)
    );

    logic [7:0]  model [BYTES];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          pend = 1'b0;
    bit          prev_ok = 1'b0;
    logic [31:0] prev_exp = '0;
    int          checks = 0, bad = 0;
    bit          done = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29) + ((a >> 7) * 13) + 5);
    endfunction

    function automatic logic [31:0] model_word(int s, int w);
        int b;
        b = (s << OFS_BITS) + 4 * w;
        return {model[b], model[b+1], model[b+2], model[b+3]};
    endfunction

    // driver: write one byte; model updated only when the write must land
    task automatic put_byte(int s, int o, logic [7:0] v, bit lands);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_slot = SLOT_BITS'(s);
        wr_ofs  = OFS_BITS'(o);
        wr_byte = v;
        if (lands) model[(s << OFS_BITS) + o] = v;
        prev_ok = 1'b0;
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en = 1'b0;
        repeat (4) @(negedge wr_clk);
    endtask

    // driver: present a read address and push the expected word
    task automatic rd_exp(int s, int w, logic [31:0] exp, string tag);
        @(negedge rd_clk);
        rd_slot = SLOT_BITS'(s);
        rd_word = WORD_BITS'(w);
        #1;
        if (prev_ok) check("R4 output held until edge", rd_data, prev_exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        prev_exp = exp;
        prev_ok  = 1'b1;
        pend     = 1'b1;
    endtask

    task automatic rd_model(int s, int w, string tag);
        rd_exp(s, w, model_word(s, w), tag);
    endtask

    // monitor: compare one registered word per issued read
    always @(posedge rd_clk) begin
        if (pend) begin
            pend = 1'b0;
            #(RD_PERIOD/4);
            if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #(RD_PERIOD * 100000);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < BYTES; i++) model[i] = '0;

        // R6: read while read reset held
        repeat (3) @(negedge rd_clk);
        rd_exp(3, 2, 32'd0, "R6 read during reset");
        @(negedge wr_clk);
        wr_rst = 1'b0;
        @(negedge rd_clk);
        rd_rst  = 1'b0;
        prev_ok = 1'b0;

        // R1: fill whole memory
        for (int a = 0; a < BYTES; a++) put_byte(a >> OFS_BITS, a % (1 << OFS_BITS), pat(a), 1'b1);
        wr_idle();

        // R2 R3: every word of slot 0
        for (int w = 0; w < NWORD; w++) rd_model(0, w, "R2/R3 slot0 word");
        // R9: both ends of the address space
        rd_model(NSLOT - 1, NWORD - 1, "R9 last word");
        rd_model(0, 0, "R9 first word");
        // R1: stride across slots
        for (int s = 1; s < NSLOT; s++) rd_model(s, (s * 7) % NWORD, "R1 stored byte");
        prev_ok = 1'b0;

        // R5: rewrite slot 3 word 0, neighbours untouched
        for (int o = 0; o < 4; o++) put_byte(3, o, 8'hA0 + 8'(o), 1'b1);
        wr_idle();
        rd_model(3, 0, "R5 rewritten slot");
        rd_model(4, 0, "R5 next slot");
        rd_model(2, 0, "R5 previous slot");
        prev_ok = 1'b0;

        // R8: single byte in lane 1 (offset 6 -> word 1)
        put_byte(2, 6, 8'h5C, 1'b1);
        wr_idle();
        rd_model(2, 1, "R8 single lane");
        rd_exp(2, 1, {pat((2 << OFS_BITS) + 4), pat((2 << OFS_BITS) + 5), 8'h5C,
                      pat((2 << OFS_BITS) + 7)}, "R8 other lanes kept");
        prev_ok = 1'b0;

        // R7: write presented under write reset is dropped
        @(negedge wr_clk);
        wr_rst = 1'b1;
        put_byte(1, 0, ~model[1 << OFS_BITS], 1'b0);
        @(negedge wr_clk);
        wr_en  = 1'b0;
        wr_rst = 1'b0;
        wr_idle();
        rd_model(1, 0, "R7 write under reset dropped");

        // R6: reset mid-stream, then recovery
        @(negedge rd_clk);
        rd_rst = 1'b1;
        prev_ok = 1'b0;
        rd_exp(5, 3, 32'd0, "R6 reset clears output");
        @(negedge rd_clk);
        rd_rst = 1'b0;
        prev_ok = 1'b0;
        rd_model(5, 3, "R6 read after reset");
        rd_model(6, 4, "R3 following word");

        repeat (3) @(negedge rd_clk);
        finish_run();
    end

endmodule